// File: doc/BRIEF.md
# Multi-band current-limit threshold selector

This block sits beside the analog front end of a load switch. Every clock it takes a digital code for the sensed load current and a code for the programmed limit reference. It chooses the current-limit threshold that applies at that moment and flags when the sensed value lies above it. It also produces an active-low overcurrent alert that trips below the limit, so a supervisor gets an early warning.

While soft-start is in progress, the threshold is capped by a ceiling that grows as the output voltage rises. Two comparator flags report this rise: output above 40% of input and output above 80% of input. Once soft-start is complete, only the absolute maximum caps the reference.

The alert trips at a fixed fraction of the reference. It is silent during soft-start, and it is released only after a hold-off measured in clock cycles. The timers that turn a long limiting condition into a shutdown live in the fault supervisor, not here.

All voltages are unsigned codes of `WIDTH` bits at 1 mV per LSB.

Top module: `ilim_select_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge sets `thresh_o` to 0, `limiting_o` to 0 and `alert_n_o` to 1.
- R2: With `ss_done_i`=0, `out_gt40_i`=0 and `out_gt80_i`=0, the threshold is the smaller of `ref_i` and `CLAMP_LO` (default 152).
- R3: With `ss_done_i`=0, `out_gt40_i`=1 and `out_gt80_i`=0, the threshold is the smaller of `ref_i` and `CLAMP_HI` (default 504).
- R4: With `ss_done_i`=0 and `out_gt80_i`=1, the threshold is the smaller of `ref_i` and `CLAMP_MAX` (default 1600), whatever the value of `out_gt40_i`.
- R5: With `ss_done_i`=1, the threshold is the smaller of `ref_i` and `CLAMP_MAX`, whatever the values of both band flags.
- R6: `limiting_o` is 1 exactly when `sense_i` is strictly greater than the threshold chosen from the same cycle's inputs.
- R7: With `ss_done_i`=1 and `sense_i` strictly greater than the trip point floor(`ref_i`*220/256), `alert_n_o` is 0 after the next edge.
- R8: While `ss_done_i`=0, `alert_n_o` is 1 after every edge. This holds even when the alert was asserted before, or when `sense_i` is above the trip point.
- R9: An asserted alert is released on the `REL_CYCLES`-th consecutive edge at which `sense_i` is at or below the trip point. A single sample above the trip point restarts that count.
- R10: `thresh_o` and `limiting_o` are registered. They reflect the inputs present at the most recent edge and are refreshed at every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sense_i | input | WIDTH | Sensed current code, 1 mV/LSB |
| ref_i | input | WIDTH | Programmed limit reference code, 1 mV/LSB |
| out_gt40_i | input | 1 | Output voltage is above 40% of input |
| out_gt80_i | input | 1 | Output voltage is above 80% of input |
| ss_done_i | input | 1 | Soft-start has completed |
| thresh_o | output | WIDTH | Active current-limit threshold |
| limiting_o | output | 1 | Sense code is above the active threshold |
| alert_n_o | output | 1 | Overcurrent alert, active low |

## Verification
Every result of this block is due one edge after the inputs that cause it: threshold, limiting flag and alert assertion all appear after the first clock edge that samples the stimulus. The alert release is the exception and comes on the `REL_CYCLES`-th qualifying edge. The driver applies one input vector per falling edge and queues the result that the requirements predict for the following rising edge. The monitor pops that entry a short delay after the rising edge, so every comparison lands exactly one register stage after its stimulus. For the release, the bench keeps its own count of below-trip samples. This places the expected rise of `alert_n_o` on the correct edge and checks it on the edge just before as well.

// File: rtl/ilim_pkg.sv
// Shared types for the current-limit threshold selector.
// Assumes nothing beyond a single clock domain.
package ilim_pkg;

    // Which ceiling applies to the limit reference.
    typedef enum logic [1:0] {
        BAND_LOW  = 2'd0,
        BAND_MID  = 2'd1,
        BAND_FULL = 2'd2
    } band_e;

endpackage

// File: rtl/ilim_band_decode.sv
// Maps the soft-start status and the output-voltage comparator flags to
// the ceiling band. Assumes the flags are already synchronous to clk.
// The 80% flag dominates the 40% flag, and completed soft-start dominates both.
module ilim_band_decode
    import ilim_pkg::*;
(
    input  logic  ss_done_i,
    input  logic  out_gt40_i,
    input  logic  out_gt80_i,
    output band_e band_o
);

    // Priority decode of the band.
    always_comb begin
        if (ss_done_i || out_gt80_i) begin
            band_o = BAND_FULL;
        end else if (out_gt40_i) begin
            band_o = BAND_MID;
        end else begin
            band_o = BAND_LOW;
        end
    end

endmodule

// File: rtl/ilim_thresh_sel.sv
// Chooses the smaller of the reference and the band ceiling, then registers
// that threshold together with the limiting comparison.
// Assumes the clamp parameters fit in WIDTH bits.
module ilim_thresh_sel
    import ilim_pkg::*;
#(
    parameter int WIDTH     = 12,
    parameter int CLAMP_LO  = 152,
    parameter int CLAMP_HI  = 504,
    parameter int CLAMP_MAX = 1600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  band_e            band_i,
    input  logic [WIDTH-1:0] sense_i,
    input  logic [WIDTH-1:0] ref_i,
    output logic [WIDTH-1:0] thresh_o,
    output logic             limiting_o
);

    localparam logic [WIDTH-1:0] LO_C  = WIDTH'(CLAMP_LO);
    localparam logic [WIDTH-1:0] HI_C  = WIDTH'(CLAMP_HI);
    localparam logic [WIDTH-1:0] MAX_C = WIDTH'(CLAMP_MAX);

    logic [WIDTH-1:0] ceiling;
    logic [WIDTH-1:0] thresh_d;

    // Ceiling for the current band.
    always_comb begin
        unique case (band_i)
            BAND_LOW: ceiling = LO_C;
            BAND_MID: ceiling = HI_C;
            default:  ceiling = MAX_C;
        endcase
    end

    // Threshold is the lower of the reference and the ceiling.
    always_comb begin
        thresh_d = (ref_i < ceiling) ? ref_i : ceiling;
    end

    // Register the threshold and the limiting comparison every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thresh_o   <= '0;
            limiting_o <= 1'b0;
        end else begin
            thresh_o   <= thresh_d;
            limiting_o <= (sense_i > thresh_d);
        end
    end

    // The threshold never exceeds the reference it was derived from.
    assert_thresh_le_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
        thresh_o <= $past(ref_i));

    // Lowest band never yields more than the low clamp.
    assert_low_band_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (band_i == BAND_LOW) |=> (thresh_o <= LO_C));

    // Middle band never yields more than the high clamp.
    assert_mid_band_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (band_i == BAND_MID) |=> (thresh_o <= HI_C));

    // A limiting flag implies the sampled sense was above the registered threshold.
    assert_limiting_consistent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        limiting_o |-> ($past(sense_i) > thresh_o));

endmodule

// File: rtl/ilim_alert_gen.sv
// Overcurrent alert: trips when sense exceeds floor(ref*TRIP_NUM/2^TRIP_SHIFT).
// It is held off during soft-start and released after REL_CYCLES consecutive
// samples at or below the trip point. The compare is done as
// sense*2^SHIFT > ref*NUM, so no divider and no discarded bits are needed.
// Assumes TRIP_NUM < 2^TRIP_SHIFT and REL_CYCLES >= 1.
module ilim_alert_gen #(
    parameter int WIDTH      = 12,
    parameter int TRIP_NUM   = 220,
    parameter int TRIP_SHIFT = 8,
    parameter int REL_CYCLES = 300000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ss_done_i,
    input  logic [WIDTH-1:0] sense_i,
    input  logic [WIDTH-1:0] ref_i,
    output logic             alert_n_o
);

    localparam int PW = WIDTH + TRIP_SHIFT;
    localparam int CW = $clog2(REL_CYCLES + 1);
    localparam logic [CW-1:0] REL_LAST = CW'(REL_CYCLES - 1);

    logic [PW-1:0] ref_scaled;
    logic [PW-1:0] sense_scaled;
    logic          above_trip;
    logic [CW-1:0] rel_cnt;

    // Scale both operands to the same fixed-point grid and compare.
    always_comb begin
        ref_scaled   = PW'(ref_i) * PW'(TRIP_NUM);
        sense_scaled = {sense_i, {TRIP_SHIFT{1'b0}}};
        above_trip   = (sense_scaled > ref_scaled);
    end

    // Alert state and release debounce counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alert_n_o <= 1'b1;
            rel_cnt   <= '0;
        end else if (!ss_done_i) begin
            alert_n_o <= 1'b1;
            rel_cnt   <= '0;
        end else if (above_trip) begin
            alert_n_o <= 1'b0;
            rel_cnt   <= '0;
        end else if (!alert_n_o) begin
            if (rel_cnt == REL_LAST) begin
                alert_n_o <= 1'b1;
                rel_cnt   <= '0;
            end else begin
                rel_cnt <= rel_cnt + 1'b1;
            end
        end else begin
            rel_cnt <= '0;
        end
    end

    // During soft-start the alert is always released on the next edge.
    assert_quiet_in_softstart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_done_i |=> alert_n_o);

    // The alert only falls after an above-trip sample in normal operation.
    assert_fall_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alert_n_o) |-> ($past(above_trip) && $past(ss_done_i)));

    // Release in normal operation only at the end of a full debounce run.
    assert_release_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(alert_n_o) && $past(ss_done_i)) |-> ($past(rel_cnt) == REL_LAST));

    // The debounce counter stays inside its window.
    assert_cnt_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rel_cnt <= REL_LAST);

endmodule

// File: rtl/ilim_select_top.sv
// Top of the current-limit threshold selector: band decode, threshold
// register with limiting flag, and debounced overcurrent alert.
// Assumes all inputs are synchronous to clk; codes are 1 mV per LSB.
module ilim_select_top
    import ilim_pkg::*;
#(
    parameter int WIDTH      = 12,
    parameter int CLAMP_LO   = 152,
    parameter int CLAMP_HI   = 504,
    parameter int CLAMP_MAX  = 1600,
    parameter int TRIP_NUM   = 220,
    parameter int TRIP_SHIFT = 8,
    parameter int REL_CYCLES = 300000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sense_i,
    input  logic [WIDTH-1:0] ref_i,
    input  logic             out_gt40_i,
    input  logic             out_gt80_i,
    input  logic             ss_done_i,
    output logic [WIDTH-1:0] thresh_o,
    output logic             limiting_o,
    output logic             alert_n_o
);

    band_e band;

    ilim_band_decode u_band (
        .ss_done_i  (ss_done_i),
        .out_gt40_i (out_gt40_i),
        .out_gt80_i (out_gt80_i),
        .band_o     (band)
    );

    ilim_thresh_sel #(
        .WIDTH     (WIDTH),
        .CLAMP_LO  (CLAMP_LO),
        .CLAMP_HI  (CLAMP_HI),
        .CLAMP_MAX (CLAMP_MAX)
    ) u_thresh (
        .clk        (clk),
        .rst_n      (rst_n),
        .band_i     (band),
        .sense_i    (sense_i),
        .ref_i      (ref_i),
        .thresh_o   (thresh_o),
        .limiting_o (limiting_o)
    );

    ilim_alert_gen #(
        .WIDTH      (WIDTH),
        .TRIP_NUM   (TRIP_NUM),
        .TRIP_SHIFT (TRIP_SHIFT),
        .REL_CYCLES (REL_CYCLES)
    ) u_alert (
        .clk       (clk),
        .rst_n     (rst_n),
        .ss_done_i (ss_done_i),
        .sense_i   (sense_i),
        .ref_i     (ref_i),
        .alert_n_o (alert_n_o)
    );

    // Reset puts every output in its idle value at the following edge.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (thresh_o == '0 && !limiting_o && alert_n_o));

endmodule

// File: tb/ilim_select_top_tb_top.sv
// Scoreboard bench: the driver queues predicted outputs, the monitor compares.
module ilim_select_top_tb_top;

    localparam int W   = 12;
    localparam int REL = 8;
    localparam int LO  = 152;
    localparam int HI  = 504;
    localparam int MX  = 1600;

    typedef struct {
        logic [W-1:0] th;
        logic         lim;
        logic         al_n;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] sense = '0;
    logic [W-1:0] refc = '0;
    logic         g40 = 1'b0;
    logic         g80 = 1'b0;
    logic         ssd = 1'b0;
    logic [W-1:0] thresh;
    logic         limiting;
    logic         alert_n;

    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 0;
    exp_t q[$];

    // bench model state for the alert
    logic m_al_n = 1'b1;
    int   m_cnt = 0;

    always #5 clk = ~clk;

    ilim_select_top #(
        .WIDTH (W), .CLAMP_LO (LO), .CLAMP_HI (HI), .CLAMP_MAX (MX),
        .TRIP_NUM (220), .TRIP_SHIFT (8), .REL_CYCLES (REL)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .sense_i (sense), .ref_i (refc),
        .out_gt40_i (g40), .out_gt80_i (g80), .ss_done_i (ssd),
        .thresh_o (thresh), .limiting_o (limiting), .alert_n_o (alert_n)
    );

    task automatic step(input int s, input int r, input bit a40, input bit a80,
                        input bit sd, input string tag);
        exp_t e;
        int ceil_v, th, trip;
        @(negedge clk);
        sense = W'(s); refc = W'(r); g40 = a40; g80 = a80; ssd = sd;
        // R2..R5 ceiling selection
        if (sd || a80) ceil_v = MX;
        else if (a40)  ceil_v = HI;
        else           ceil_v = LO;
        th = (r < ceil_v) ? r : ceil_v;
        trip = (r * 220) >> 8;
        // R7..R9 alert expectation
        if (!sd) begin
            m_al_n = 1'b1; m_cnt = 0;
        end else if (s > trip) begin
            m_al_n = 1'b0; m_cnt = 0;
        end else if (!m_al_n) begin
            if (m_cnt == REL - 1) begin m_al_n = 1'b1; m_cnt = 0; end
            else m_cnt++;
        end else begin
            m_cnt = 0;
        end
        e.th = W'(th); e.lim = (s > th); e.al_n = m_al_n; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compare one edge after each driven vector
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && q.size() > 0) begin
                e = q.pop_front();
                n_run++;
                if (thresh !== e.th || limiting !== e.lim || alert_n !== e.al_n) begin
                    n_fail++;
                    $display("FAIL %s: got th=%0d lim=%0b al_n=%0b exp th=%0d lim=%0b al_n=%0b",
                             e.tag, thresh, limiting, alert_n, e.th, e.lim, e.al_n);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang exp completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state while rst_n is low
        sense = 12'd4000; refc = 12'd100; ssd = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        n_run++;
        if (thresh !== '0 || limiting !== 1'b0 || alert_n !== 1'b1) begin
            n_fail++;
            $display("FAIL R1: got th=%0d lim=%0b al_n=%0b exp th=0 lim=0 al_n=1",
                     thresh, limiting, alert_n);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2: low band
        step(100, 1000, 0, 0, 0, "R2 low band clamp");
        step(153, 1000, 0, 0, 0, "R6 above low clamp");
        step(152, 1000, 0, 0, 0, "R6 equal not limiting");
        step(50, 100, 0, 0, 0, "R2 reference below clamp");
        // R3: middle band
        step(505, 1000, 1, 0, 0, "R3 mid band clamp");
        step(300, 400, 1, 0, 0, "R3 reference below clamp");
        // R4: upper band, 80% flag dominant
        step(1700, 2000, 1, 1, 0, "R4 full clamp");
        step(1100, 1200, 1, 1, 0, "R4 reference below clamp");
        step(900, 2000, 0, 1, 0, "R4 80 flag without 40 flag");
        // R8: alert silent in soft-start even far above trip
        step(4000, 1000, 1, 1, 0, "R8 suppressed in soft-start");
        // R5: normal operation ignores band flags
        step(100, 2000, 0, 0, 1, "R5 normal max clamp");
        step(100, 1000, 1, 0, 1, "R5 normal reference");
        // R7: trip point at ref 1000 is 859
        step(859, 1000, 0, 0, 1, "R7 at trip no alert");
        step(860, 1000, 0, 0, 1, "R7 above trip alert");
        // R9: release after REL samples below trip
        for (int i = 0; i < REL; i++) step(500, 1000, 0, 0, 1, "R9 release debounce");
        // R9: restart of the count by one sample above trip
        step(900, 1000, 0, 0, 1, "R7 trip again");
        for (int i = 0; i < 4; i++) step(500, 1000, 0, 0, 1, "R9 partial count");
        step(870, 1000, 0, 0, 1, "R9 count restart");
        for (int i = 0; i < REL; i++) step(500, 1000, 0, 0, 1, "R9 full recount");
        // R8: dropping soft-start releases an asserted alert at once
        step(950, 1000, 0, 0, 1, "R7 assert before drop");
        step(950, 1000, 0, 0, 0, "R8 drop releases");
        // R10: mixed patterns refreshed every cycle
        for (int i = 0; i < 300; i++) begin
            int rs, rr;
            rr = int'($urandom_range(0, 4095));
            rs = (i % 3 == 0) ? int'($urandom_range(0, 4095)) : rr - 200 + int'($urandom_range(0, 400));
            if (rs < 0) rs = 0;
            if (rs > 4095) rs = 4095;
            step(rs, rr, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 (i % 40) > 5, "R10 mixed patterns");
        end
        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule